// File: doc/BRIEF.md
# Replicated Multiport Register File

This block is a small, fast register array. It has separate write ports and read ports, and no port both reads and writes. Every write port and every read port decodes its own address into a one-hot select over the entries. Writes are registered on the rising clock edge. Reads are combinational: a read port returns the word stored at its address in the same cycle the address is presented.

The storage is built as identical copies that receive every write in the same cycle. Each copy serves its own group of read ports, so each copy needs only a fraction of the total read ports. A read that hits an entry being written in the same cycle returns the new write data through a per-port bypass multiplexer. The file does not arbitrate between write ports. The issuing logic must keep enabled write ports on distinct entries.

The block is sized by parameters: entry count, word width, write ports, read ports per copy and copy count. The default is two copies of 32 × 64 bits, with 4 write ports and 4 read ports per copy. A single copy with 9 read ports and 4 write ports is the same RTL with different parameter values.

Top module: `rf_replicated`

## Requirements
- R1: While `rst` is high at a rising edge, every entry is cleared to zero. Once reset is released, every read port returns zero for any entry that has not been written since, unless that entry is being written in the current cycle.
- R2: A write takes effect on the rising edge of `clk`. In the following cycle, a read of that entry with no same-cycle write to it returns the written word.
- R3: Each read port returns, in the same cycle, the stored word at its own address. This is independent of the addresses on the other read ports.
- R4: When a read port's address equals the address of an enabled write port in the same cycle, that read port returns the write port's data instead of the stored word.
- R5: A write port whose enable bit is 0 changes no entry. Its address and data give no bypass.
- R6: All copies are written together. Read port r belongs to copy r / RD_PER_COPY (integer division). Read ports in different copies that present the same address return the same word.
- R7: Enabled write ports must target distinct entries in any one cycle. All such writes land at the same clock edge.
- R8: Port fields are packed by index. Write port p uses `wr_en[p]`, `wr_addr[p*AW +: AW]` and `wr_data[p*DATA_W +: DATA_W]`. Read port r uses `rd_addr[r*AW +: AW]` and `rd_data[r*DATA_W +: DATA_W]`. AW is ceil(log2(N_ENTRY)), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all entries |
| wr_en | input | N_WR | Write enable, one bit per write port |
| wr_addr | input | N_WR*AW | Write entry index, one field per write port |
| wr_data | input | N_WR*DATA_W | Write word, one field per write port |
| rd_addr | input | N_COPY*RD_PER_COPY*AW | Read entry index, one field per read port |
| rd_data | output | N_COPY*RD_PER_COPY*DATA_W | Read word, one field per read port |

## Verification
A corrupted or missed write shows up on the very next cycle, at any read port that addresses that entry. A write landing in the wrong entry shows up at the first later read of either the intended entry or the victim entry. A copy that drifts from its twin appears as a difference between read ports of separate groups given the same address. A broken bypass only shows in the cycle of the write itself, so the stimulus often aims reads at entries being written in that same cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int RF_ENTRIES  = 32;
  localparam int RF_WIDTH    = 64;
  localparam int RF_WPORTS   = 4;
  localparam int RF_RPORTS   = 4;
  localparam int RF_COPIES   = 2;

  // Index width for an array of n entries, never below one bit.
  function automatic int rf_addr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rf_addr_decode.sv
module rf_addr_decode #(
  parameter int N_ENTRY = 32,
  parameter int AW      = 5
) (
  input  logic               en,
  input  logic [AW-1:0]      addr,
  output logic [N_ENTRY-1:0] sel
);

  // One select line per entry; an index past the last entry selects nothing.
  for (genvar e = 0; e < N_ENTRY; e++) begin : g_line
    assign sel[e] = en && (addr == AW'(e));
  end

endmodule

// File: rtl/rf_rd_port.sv
module rf_rd_port #(
  parameter int N_ENTRY = 32,
  parameter int DATA_W  = 64,
  parameter int N_WR    = 4,
  parameter int AW      = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             rd_addr,
  input  logic [N_ENTRY*DATA_W-1:0] store_flat,
  input  logic [N_WR-1:0]           wr_en,
  input  logic [N_WR*AW-1:0]        wr_addr,
  input  logic [N_WR*DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]         rd_data
);

  logic [N_ENTRY-1:0] rd_sel;
  logic [DATA_W-1:0]  stored_word;
  logic               byp_hit;
  logic [DATA_W-1:0]  byp_word;

  rf_addr_decode #(.N_ENTRY(N_ENTRY), .AW(AW)) u_dec (
    .en   (1'b1),
    .addr (rd_addr),
    .sel  (rd_sel)
  );

  // AND-OR column select over the entries.
  always_comb begin
    stored_word = '0;
    for (int e = 0; e < N_ENTRY; e++) begin
      if (rd_sel[e]) stored_word = stored_word | store_flat[e*DATA_W +: DATA_W];
    end
  end

  // Same-cycle forwarding; scanning downward lets the lowest port win.
  always_comb begin
    byp_hit  = 1'b0;
    byp_word = '0;
    for (int p = N_WR - 1; p >= 0; p--) begin
      if (wr_en[p] && (wr_addr[p*AW +: AW] == rd_addr)) begin
        byp_hit  = 1'b1;
        byp_word = wr_data[p*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data = byp_hit ? byp_word : stored_word;

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !byp_hit) |-> (rd_data == '0)); // R1

endmodule

// File: rtl/rf_copy.sv
module rf_copy #(
  parameter int N_ENTRY = 32,
  parameter int DATA_W  = 64,
  parameter int N_WR    = 4,
  parameter int N_RD    = 4,
  parameter int AW      = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_WR*N_ENTRY-1:0]   wr_sel,
  input  logic [N_WR-1:0]           wr_en,
  input  logic [N_WR*AW-1:0]        wr_addr,
  input  logic [N_WR*DATA_W-1:0]    wr_data,
  input  logic [N_RD*AW-1:0]        rd_addr,
  output logic [N_RD*DATA_W-1:0]    rd_data
);

  logic [DATA_W-1:0]         mem_q   [N_ENTRY];
  logic [DATA_W-1:0]         mem_nxt [N_ENTRY];
  logic [N_ENTRY-1:0]        mem_hit;
  logic [N_ENTRY*DATA_W-1:0] store_flat;

  // Per-entry write word: the lowest-numbered selecting port is taken.
  always_comb begin
    for (int e = 0; e < N_ENTRY; e++) begin
      mem_hit[e] = 1'b0;
      mem_nxt[e] = '0;
      for (int p = N_WR - 1; p >= 0; p--) begin
        if (wr_sel[p*N_ENTRY + e]) begin
          mem_hit[e] = 1'b1;
          mem_nxt[e] = wr_data[p*DATA_W +: DATA_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < N_ENTRY; e++) begin
      if (rst)             mem_q[e] <= '0;
      else if (mem_hit[e]) mem_q[e] <= mem_nxt[e];
    end
  end

  for (genvar e = 0; e < N_ENTRY; e++) begin : g_flat
    assign store_flat[e*DATA_W +: DATA_W] = mem_q[e];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(mem_hit[e])) |-> (mem_q[e] == $past(mem_nxt[e]))); // R2
    AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(mem_hit[e])) |-> (mem_q[e] == $past(mem_q[e]))); // R5
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    rf_rd_port #(
      .N_ENTRY (N_ENTRY),
      .DATA_W  (DATA_W),
      .N_WR    (N_WR),
      .AW      (AW)
    ) u_port (
      .clk        (clk),
      .rst        (rst),
      .rd_addr    (rd_addr[r*AW +: AW]),
      .store_flat (store_flat),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_data    (rd_data[r*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/rf_replicated.sv
module rf_replicated #(
  parameter int N_ENTRY     = rf_pkg::RF_ENTRIES,
  parameter int DATA_W      = rf_pkg::RF_WIDTH,
  parameter int N_WR        = rf_pkg::RF_WPORTS,
  parameter int RD_PER_COPY = rf_pkg::RF_RPORTS,
  parameter int N_COPY      = rf_pkg::RF_COPIES,
  localparam int AW         = rf_pkg::rf_addr_bits(N_ENTRY),
  localparam int N_RD_TOT   = N_COPY * RD_PER_COPY
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_WR-1:0]            wr_en,
  input  logic [N_WR*AW-1:0]         wr_addr,
  input  logic [N_WR*DATA_W-1:0]     wr_data,
  input  logic [N_RD_TOT*AW-1:0]     rd_addr,
  output logic [N_RD_TOT*DATA_W-1:0] rd_data
);

  logic [N_WR*N_ENTRY-1:0] wr_sel;

  // One word-line decoder per write port, shared by every copy.
  for (genvar p = 0; p < N_WR; p++) begin : g_wdec
    rf_addr_decode #(.N_ENTRY(N_ENTRY), .AW(AW)) u_dec (
      .en   (wr_en[p]),
      .addr (wr_addr[p*AW +: AW]),
      .sel  (wr_sel[p*N_ENTRY +: N_ENTRY])
    );
  end

  for (genvar c = 0; c < N_COPY; c++) begin : g_copy
    rf_copy #(
      .N_ENTRY (N_ENTRY),
      .DATA_W  (DATA_W),
      .N_WR    (N_WR),
      .N_RD    (RD_PER_COPY),
      .AW      (AW)
    ) u_copy (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (wr_sel),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr[c*RD_PER_COPY*AW +: RD_PER_COPY*AW]),
      .rd_data (rd_data[c*RD_PER_COPY*DATA_W +: RD_PER_COPY*DATA_W])
    );
  end

  // Issue-side contract: no two enabled write ports on one entry.
  for (genvar i = 0; i < N_WR; i++) begin : g_wchk_i
    for (genvar j = i + 1; j < N_WR; j++) begin : g_wchk_j
      AST_WR_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        !(wr_en[i] && wr_en[j] && (wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW]))); // R7
    end
  end

  // Mirrored copies must agree whenever two groups read the same entry.
  for (genvar c = 1; c < N_COPY; c++) begin : g_mchk_c
    for (genvar r = 0; r < RD_PER_COPY; r++) begin : g_mchk_r
      AST_COPY_MATCH: assert property (@(posedge clk) disable iff (rst)
        (rd_addr[r*AW +: AW] == rd_addr[(c*RD_PER_COPY + r)*AW +: AW]) |->
        (rd_data[r*DATA_W +: DATA_W] == rd_data[(c*RD_PER_COPY + r)*DATA_W +: DATA_W])); // R6
    end
  end

endmodule

// File: tb/sim_rf_replicated.sv
`timescale 1ns/1ps
module sim_rf_replicated;

  localparam int NE  = 32;
  localparam int DW  = 64;
  localparam int NW  = 4;
  localparam int RPC = 4;
  localparam int NC  = 2;
  localparam int AW  = 5;
  localparam int NR  = NC * RPC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          w_en [NW];
  logic [AW-1:0] w_ad [NW];
  logic [DW-1:0] w_d  [NW];
  logic [AW-1:0] r_ad [NR];
  logic [DW-1:0] model [NE];

  logic [NW-1:0]    wr_en;
  logic [NW*AW-1:0] wr_addr;
  logic [NW*DW-1:0] wr_data;
  logic [NR*AW-1:0] rd_addr;
  logic [NR*DW-1:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always_comb begin
    for (int p = 0; p < NW; p++) begin
      wr_en[p]               = w_en[p];
      wr_addr[p*AW +: AW]    = w_ad[p];
      wr_data[p*DW +: DW]    = w_d[p];
    end
    for (int r = 0; r < NR; r++) rd_addr[r*AW +: AW] = r_ad[r];
  end

  rf_replicated #(
    .N_ENTRY(NE), .DATA_W(DW), .N_WR(NW), .RD_PER_COPY(RPC), .N_COPY(NC)
  ) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic fwd_hit(input logic [AW-1:0] a);
    for (int p = 0; p < NW; p++) if (w_en[p] && w_ad[p] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    for (int p = 0; p < NW; p++) if (w_en[p] && w_ad[p] == a) return w_d[p];
    return model[a];
  endfunction

  task automatic chk(input string tag, input int port, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s read port %0d: actual %h expected %h", tag, port, act, exp);
    end
  endtask

  task automatic idle_inputs();
    for (int p = 0; p < NW; p++) begin
      w_en[p] = 1'b0; w_ad[p] = '0; w_d[p] = '0;
    end
  endtask

  // Inputs set at negedge, outputs compared 1 ns later, model updated after posedge.
  task automatic step(input string tag);
    #1;
    for (int r = 0; r < NR; r++)
      chk(fwd_hit(r_ad[r]) ? "R4" : tag, r, rd_data[r*DW +: DW], exp_read(r_ad[r]));
    @(posedge clk);
    if (!rst)
      for (int p = NW - 1; p >= 0; p--) if (w_en[p]) model[w_ad[p]] = w_d[p];
    @(negedge clk);
  endtask

  task automatic rand_cycle();
    logic [AW-1:0] a;
    logic clash;
    for (int p = 0; p < NW; p++) begin
      w_en[p] = ($urandom % 3) != 0;
      w_d[p]  = {$urandom, $urandom};
      do begin
        a = AW'($urandom);
        clash = 1'b0;
        for (int q = 0; q < p; q++) if (w_en[q] && w_ad[q] == a) clash = 1'b1;
      end while (w_en[p] && clash);
      w_ad[p] = a;
    end
    for (int r = 0; r < NR; r++)
      r_ad[r] = ($urandom % 2) ? w_ad[$urandom % NW] : AW'($urandom);
  endtask

  initial begin
    #(5.0 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0021));
    for (int e = 0; e < NE; e++) model[e] = '0;
    idle_inputs();
    for (int r = 0; r < NR; r++) r_ad[r] = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every entry reads zero after reset, on all ports of both copies.
    for (int k = 0; k < NE / NR; k++) begin
      for (int r = 0; r < NR; r++) r_ad[r] = AW'(k*NR + r);
      step("R1");
    end

    // R2, R8: port 3 writes entry 5; next cycle every port reads it.
    idle_inputs();
    w_en[3] = 1'b1; w_ad[3] = 5'd5; w_d[3] = 64'hA5A5_0000_1234_FFFF;
    for (int r = 0; r < NR; r++) r_ad[r] = 5'd20;
    step("R2");
    idle_inputs();
    for (int r = 0; r < NR; r++) r_ad[r] = 5'd5;
    step("R2");

    // R4: write port 2 to entry 9 while ports in both copies read 9.
    w_en[2] = 1'b1; w_ad[2] = 5'd9; w_d[2] = 64'hDEAD_BEEF_0BAD_F00D;
    for (int r = 0; r < NR; r++) r_ad[r] = (r % 2) ? 5'd9 : 5'd5;
    step("R3");
    idle_inputs();

    // R5: disabled port aimed at entry 5 neither bypasses nor writes.
    w_en[1] = 1'b0; w_ad[1] = 5'd5; w_d[1] = 64'h1111_2222_3333_4444;
    for (int r = 0; r < NR; r++) r_ad[r] = 5'd5;
    step("R5");
    idle_inputs();
    step("R5");

    // R7: four ports write four distinct entries in one edge.
    for (int p = 0; p < NW; p++) begin
      w_en[p] = 1'b1; w_ad[p] = AW'(28 + p); w_d[p] = {32'hC0DE_0000 + 32'(p), 32'h0};
    end
    for (int r = 0; r < NR; r++) r_ad[r] = AW'(r);
    step("R3");
    idle_inputs();
    // R6: copy 0 and copy 1 read the same four new entries.
    for (int r = 0; r < NR; r++) r_ad[r] = AW'(28 + (r % RPC));
    step("R7");

    // Random traffic mixing bypass hits, disabled ports and plain reads.
    for (int n = 0; n < 3000; n++) begin
      rand_cycle();
      step("R3");
    end

    idle_inputs();
    for (int k = 0; k < NE / NR; k++) begin
      for (int r = 0; r < NR; r++) r_ad[r] = AW'(k*NR + NR - 1 - r);
      step("R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule